// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block decides which of sixteen fixed priority levels a processor core services next, and it keeps track of nested service. Level 0 is the most urgent and level 15 the least. The fixed levels are: 0 debug/emulation entry, 1 reset, 2 non-maskable interrupt, 3 synchronous exception, 5 hardware error, 6 core timer, and 7 through 15 general-purpose interrupts. Level 4 is a hole that never holds a request. Requests are captured as pending bits. The block keeps one in-service bit per level. A pending event is entered only when its level is strictly more urgent than every level already in service, so a handler can be preempted by a more urgent one without losing its own in-service state.

When an event is entered, the block gives a one-cycle take pulse and the level number, which the core uses as its vector index. When the core finishes a handler, it pulses the return input. This retires only the most urgent in-service level. The levels below it then continue, or a pending event that was blocked can now be entered.

The sequencer has two states. SEQ_BOOT is the state during reset and on the first clock after reset. There it takes action ACT_BOOT, which reports level 1 as entered, and then moves to SEQ_RUN. SEQ_RUN stays in SEQ_RUN. On each clock it chooses one action, in this order:
- ACT_RETIRE when a return strobe is present.
- ACT_ENTER when an eligible pending level beats the in-service levels.
- ACT_IDLE otherwise.

Top module: `nested_event_ctrl`

## Requirements
- R1: While reset is asserted, the take pulse, every in-service bit and the valid flag are 0. Pending and mask bits are cleared. On the first clock after reset is released, the block enters level 1, with the take pulse high, vector 1 and in-service equal to 0x0002.
- R2: When several eligible levels are pending together, they are entered in order of level number, lowest number first.
- R3: A pending eligible level is entered only if its number is strictly lower than every in-service level. Entering it leaves the lower-priority in-service bits set. A level of equal or higher number waits.
- R4: A return strobe clears only the in-service bit of the lowest-numbered in-service level, and no level is entered on that clock. A return strobe with nothing in service changes nothing.
- R5: The mask write port loads a 16-bit register in which bit i belongs to level i. Levels 5 to 15 are eligible only while their mask bit is 1, and a masked request stays pending. Levels 0 to 3 ignore the mask.
- R6: Level 4 never becomes pending, in service or entered, even when mask bit 4 is written to 1.
- R7: Level 2 is raised by a rising edge on the NMI pin, or by a one-cycle pulse on either the watchdog-expiry input or the software NMI input.
- R8: Bit j of the software-raise input, pulsed for one cycle, makes general-purpose level 7+j pending, in the same way as its hardware line does.
- R9: Hardware request lines are edge-triggered. A line held high produces one entry only, and it must return low and rise again before it can request again.
- R10: Suppose a request rises before clock edge k, and the block is otherwise idle with the level enabled. Then the level is pending after edge k, the take pulse is high with the level number on the take vector for exactly the cycle after edge k+1, and it is low again after edge k+2.
- R11: The current-level output shows the lowest-numbered in-service level, with the valid flag high whenever any in-service bit is set.
- R12: An exception request is entered ahead of any general-purpose service in progress, regardless of the mask, and emulation entry preempts an exception in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_req | input | 1 | Emulation entry request (level 0), edge-triggered |
| rst_evt_req | input | 1 | Reset event request (level 1), edge-triggered |
| nmi_pin | input | 1 | External NMI line (level 2), edge-triggered |
| nmi_wdog | input | 1 | Watchdog expiry pulse (level 2) |
| nmi_sw | input | 1 | Software NMI pulse (level 2) |
| exc_req | input | 1 | Synchronous exception request (level 3), edge-triggered |
| hwerr_req | input | 1 | Hardware error request (level 5), edge-triggered |
| tmr_req | input | 1 | Core timer request (level 6), edge-triggered |
| gp_req | input | GP_COUNT | General-purpose request lines, bit j for level 7+j |
| sw_raise | input | GP_COUNT | Software raise pulses, bit j for level 7+j |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 16 | New mask value, bit i for level i |
| ret_strobe | input | 1 | Return-from-event pulse |
| take_pulse | output | 1 | One-cycle event entry indication |
| take_vec | output | 4 | Level being entered (vector index) |
| cur_vld | output | 1 | Some level is in service |
| cur_level | output | 4 | Most urgent in-service level |
| in_service | output | 16 | In-service bit per level |

## Verification
The bench builds the block with its default of nine general-purpose levels, which gives the full sixteen-level map with the hole at level 4. With this build the bench can reach nesting three deep across the exception, emulation and general-purpose ranges. It can also reach the top general-purpose level 15 through the software-raise port and the highest mask bit. A return strobe can be driven on the same clock as an entry would otherwise happen, so that collision is covered.

// File: rtl/evc_pkg.sv
package evc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int EVC_LVL_EMU  = 0;
    localparam int EVC_LVL_RST  = 1;
    localparam int EVC_LVL_NMI  = 2;
    localparam int EVC_LVL_EXC  = 3;
    localparam int EVC_LVL_RSV  = 4;
    localparam int EVC_LVL_HWE  = 5;
    localparam int EVC_LVL_TMR  = 6;
    localparam int EVC_GP_FIRST = 7;
    localparam int EVC_UNMASKED_CNT = 4;

    typedef enum logic {
        SEQ_BOOT = 1'b0,
        SEQ_RUN  = 1'b1
    } evc_state_e;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_BOOT   = 2'd1,
        ACT_RETIRE = 2'd2,
        ACT_ENTER  = 2'd3
    } evc_act_e;
endpackage

// File: rtl/evc_capture.sv
module evc_capture import evc_pkg::*; #(
    parameter int NUM_LVL = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] hw_lvl,
    input  logic [NUM_LVL-1:0] strobe_lvl,
    input  logic [NUM_LVL-1:0] clr_lvl,
    output logic [NUM_LVL-1:0] pend
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [NUM_LVL-1:0] KEEP = ~(NUM_LVL'(1) << EVC_LVL_RSV);

    logic [NUM_LVL-1:0] hw_q;
    logic [NUM_LVL-1:0] rise;
    logic [NUM_LVL-1:0] pend_d;

    // Per-level edge detector
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hw_q[i] <= 1'b0;
            end else begin
                hw_q[i] <= hw_lvl[i];
            end
        end
        assign rise[i] = hw_lvl[i] & ~hw_q[i];
    end

    // A new event on the same clock as an entry is kept pending
    always_comb begin
        pend_d = ((pend & ~clr_lvl) | rise | strobe_lvl) & KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend_d;
        end
    end
endmodule

// File: rtl/evc_arbiter.sv
module evc_arbiter import evc_pkg::*; #(
    parameter int NUM_LVL = 16,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] pend,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] ins,
    output logic               cand_vld,
    output logic [LVL_W-1:0]   cand_lvl,
    output logic               top_vld,
    output logic [LVL_W-1:0]   top_lvl
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [NUM_LVL-1:0] UNMASKED = NUM_LVL'((1 << EVC_UNMASKED_CNT) - 1);
    localparam logic [NUM_LVL-1:0] KEEP     = ~(NUM_LVL'(1) << EVC_LVL_RSV);

    logic [NUM_LVL-1:0] elig;

    always_comb begin
        elig = pend & (mask | UNMASKED) & KEEP;
    end

    // Most urgent eligible pending level
    always_comb begin
        cand_vld = 1'b0;
        cand_lvl = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (elig[i]) begin
                cand_vld = 1'b1;
                cand_lvl = LVL_W'(i);
            end
        end
    end

    // Most urgent in-service level
    always_comb begin
        top_vld = 1'b0;
        top_lvl = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (ins[i]) begin
                top_vld = 1'b1;
                top_lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/evc_sequencer.sv
module evc_sequencer import evc_pkg::*; #(
    parameter int NUM_LVL = 16,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_strobe,
    input  logic               cand_vld,
    input  logic [LVL_W-1:0]   cand_lvl,
    input  logic               top_vld,
    input  logic [LVL_W-1:0]   top_lvl,
    output logic [NUM_LVL-1:0] clr_lvl,
    output logic [NUM_LVL-1:0] ins,
    output logic               take_pulse,
    output logic [LVL_W-1:0]   take_vec
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [NUM_LVL-1:0] ONE     = NUM_LVL'(1);
    localparam logic [LVL_W-1:0]   RST_LVL = LVL_W'(EVC_LVL_RST);

    evc_state_e state_q;
    evc_state_e state_nx;
    evc_act_e   act;
    logic       beats_top;

    always_comb begin
        beats_top = cand_vld && (!top_vld || (cand_lvl < top_lvl));
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_BOOT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transition and action selection
    always_comb begin
        state_nx = state_q;
        act      = ACT_IDLE;
        unique case (state_q)
            SEQ_BOOT: begin
                act      = ACT_BOOT;
                state_nx = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (ret_strobe) begin
                    act = ACT_RETIRE;
                end else if (beats_top) begin
                    act = ACT_ENTER;
                end
            end
            default: begin
                state_nx = SEQ_BOOT;
            end
        endcase
    end

    always_comb begin
        clr_lvl = (act == ACT_ENTER) ? (ONE << cand_lvl) : '0;
    end

    // Output and in-service register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins        <= '0;
            take_pulse <= 1'b0;
            take_vec   <= '0;
        end else begin
            take_pulse <= 1'b0;
            unique case (act)
                ACT_BOOT: begin
                    ins        <= ins | (ONE << RST_LVL);
                    take_pulse <= 1'b1;
                    take_vec   <= RST_LVL;
                end
                ACT_RETIRE: begin
                    if (top_vld) begin
                        ins <= ins & ~(ONE << top_lvl);
                    end
                end
                ACT_ENTER: begin
                    ins        <= ins | (ONE << cand_lvl);
                    take_pulse <= 1'b1;
                    take_vec   <= cand_lvl;
                end
                default: begin
                    ins <= ins;
                end
            endcase
        end
    end
endmodule

// File: rtl/nested_event_ctrl.sv
module nested_event_ctrl import evc_pkg::*; #(
    parameter int GP_COUNT = 9,
    localparam int NUM_LVL = EVC_GP_FIRST + GP_COUNT,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                emu_req,
    input  logic                rst_evt_req,
    input  logic                nmi_pin,
    input  logic                nmi_wdog,
    input  logic                nmi_sw,
    input  logic                exc_req,
    input  logic                hwerr_req,
    input  logic                tmr_req,
    input  logic [GP_COUNT-1:0] gp_req,
    input  logic [GP_COUNT-1:0] sw_raise,
    input  logic                mask_we,
    input  logic [NUM_LVL-1:0]  mask_wdata,
    input  logic                ret_strobe,
    output logic                take_pulse,
    output logic [LVL_W-1:0]    take_vec,
    output logic                cur_vld,
    output logic [LVL_W-1:0]    cur_level,
    output logic [NUM_LVL-1:0]  in_service
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NUM_LVL-1:0] hw_vec;
    logic [NUM_LVL-1:0] strobe_vec;
    logic [NUM_LVL-1:0] pend;
    logic [NUM_LVL-1:0] clr_lvl;
    logic [NUM_LVL-1:0] mask_q;
    logic               cand_vld;
    logic [LVL_W-1:0]   cand_lvl;

    always_comb begin
        hw_vec                             = '0;
        hw_vec[EVC_LVL_EMU]                = emu_req;
        hw_vec[EVC_LVL_RST]                = rst_evt_req;
        hw_vec[EVC_LVL_NMI]                = nmi_pin;
        hw_vec[EVC_LVL_EXC]                = exc_req;
        hw_vec[EVC_LVL_HWE]                = hwerr_req;
        hw_vec[EVC_LVL_TMR]                = tmr_req;
        hw_vec[NUM_LVL-1:EVC_GP_FIRST]     = gp_req;
        strobe_vec                         = '0;
        strobe_vec[EVC_LVL_NMI]            = nmi_wdog | nmi_sw;
        strobe_vec[NUM_LVL-1:EVC_GP_FIRST] = sw_raise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    evc_capture #(.NUM_LVL(NUM_LVL)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_lvl     (hw_vec),
        .strobe_lvl (strobe_vec),
        .clr_lvl    (clr_lvl),
        .pend       (pend)
    );

    evc_arbiter #(.NUM_LVL(NUM_LVL)) u_arb (
        .pend     (pend),
        .mask     (mask_q),
        .ins      (in_service),
        .cand_vld (cand_vld),
        .cand_lvl (cand_lvl),
        .top_vld  (cur_vld),
        .top_lvl  (cur_level)
    );

    evc_sequencer #(.NUM_LVL(NUM_LVL)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_strobe (ret_strobe),
        .cand_vld   (cand_vld),
        .cand_lvl   (cand_lvl),
        .top_vld    (cur_vld),
        .top_lvl    (cur_level),
        .clr_lvl    (clr_lvl),
        .ins        (in_service),
        .take_pulse (take_pulse),
        .take_vec   (take_vec)
    );
endmodule

// File: rtl/evc_checker.sv
module evc_checker import evc_pkg::*; #(
    parameter int NUM_LVL = 16,
    localparam int LVL_W = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ret_strobe,
    input logic               take_pulse,
    input logic [LVL_W-1:0]   take_vec,
    input logic               cur_vld,
    input logic [LVL_W-1:0]   cur_level,
    input logic [NUM_LVL-1:0] in_service,
    input logic [NUM_LVL-1:0] mask_q
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [LVL_W-1:0] RSV     = LVL_W'(EVC_LVL_RSV);
    localparam logic [LVL_W-1:0] GATE_LO = LVL_W'(EVC_LVL_HWE);

    AST_RSV_NEVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_service[EVC_LVL_RSV] && !(take_pulse && take_vec == RSV)); // R6

    AST_ENTRY_IS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> (cur_vld && cur_level == take_vec)); // R3

    AST_RETIRE_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && cur_vld) |=>
            (!take_pulse && ($countones(in_service) == $countones($past(in_service)) - 1))); // R4

    AST_MASK_GATES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pulse && take_vec >= GATE_LO) |-> ((($past(mask_q) >> take_vec) & NUM_LVL'(1)) != '0)); // R5

    AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pulse && $past(cur_vld)) |-> (take_vec < $past(cur_level))); // R3
endmodule

bind nested_event_ctrl evc_checker #(.NUM_LVL(NUM_LVL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_strobe (ret_strobe),
    .take_pulse (take_pulse),
    .take_vec   (take_vec),
    .cur_vld    (cur_vld),
    .cur_level  (cur_level),
    .in_service (in_service),
    .mask_q     (mask_q)
);

// File: tb/nested_event_ctrl_tb.sv
module nested_event_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int GP = 9;
    localparam int N  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          emu_req = 0, rst_evt_req = 0, nmi_pin = 0, nmi_wdog = 0, nmi_sw = 0;
    logic          exc_req = 0, hwerr_req = 0, tmr_req = 0;
    logic [GP-1:0] gp_req = '0, sw_raise = '0;
    logic          mask_we = 0;
    logic [N-1:0]  mask_wdata = '0;
    logic          ret_strobe = 0;
    logic          take_pulse;
    logic [3:0]    take_vec;
    logic          cur_vld;
    logic [3:0]    cur_level;
    logic [N-1:0]  in_service;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    nested_event_ctrl #(.GP_COUNT(GP)) u_dut (
        .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .rst_evt_req(rst_evt_req),
        .nmi_pin(nmi_pin), .nmi_wdog(nmi_wdog), .nmi_sw(nmi_sw), .exc_req(exc_req),
        .hwerr_req(hwerr_req), .tmr_req(tmr_req), .gp_req(gp_req), .sw_raise(sw_raise),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ret_strobe(ret_strobe),
        .take_pulse(take_pulse), .take_vec(take_vec), .cur_vld(cur_vld),
        .cur_level(cur_level), .in_service(in_service)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_take(input int lvl, input string tag);
        exp_q.push_back(lvl);
        tag_q.push_back(tag);
    endtask

    task automatic do_ret();
        ret_strobe = 1'b1;
        tick(1);
        ret_strobe = 1'b0;
        tick(2);
    endtask

    task automatic wr_mask(input logic [N-1:0] v);
        mask_we    = 1'b1;
        mask_wdata = v;
        tick(1);
        mask_we    = 1'b0;
    endtask

    task automatic sw_pulse(input int bitpos);
        sw_raise[bitpos] = 1'b1;
        tick(1);
        sw_raise = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Scoreboard monitor: every entry must match the next expected level
    always @(negedge clk) begin
        if (rst_n && take_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected entry (R3/R5/R9)", int'(take_vec), 99);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(int'(take_vec) == e, t, int'(take_vec), e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        // R1 reset state and boot entry
        tick(3);
        chk(take_pulse == 1'b0, "R1 take during reset", int'(take_pulse), 0);
        chk(in_service == '0 && !cur_vld, "R1 in-service during reset", int'(in_service), 0);
        expect_take(1, "R1 boot entry vector");
        rst_n = 1'b1;
        tick(1);
        chk(in_service == 16'h0002, "R1 boot in-service", int'(in_service), 16'h0002);
        chk(cur_vld && cur_level == 4'd1, "R11 current level after boot", int'(cur_level), 1);
        do_ret();
        chk(in_service == '0, "R4 return from boot", int'(in_service), 0);

        // R5 masked request stays pending until its mask bit is set
        gp_req[0] = 1'b1;
        tick(5);
        chk(in_service == '0, "R5 masked level not entered", int'(in_service), 0);
        expect_take(7, "R5 entry after unmask");
        wr_mask(16'h0080);
        tick(3);
        chk(in_service == 16'h0080, "R5 level 7 in service", int'(in_service), 16'h0080);
        gp_req[0] = 1'b0;

        // R3 nesting: lower waits, higher preempts
        wr_mask(16'h02C0);
        gp_req[2] = 1'b1;
        tick(4);
        chk(in_service == 16'h0080, "R3 lower level waits", int'(in_service), 16'h0080);
        expect_take(6, "R3 timer preempts");
        tmr_req = 1'b1;
        tick(4);
        chk(in_service == 16'h00C0, "R3 nested in-service", int'(in_service), 16'h00C0);
        chk(cur_level == 4'd6, "R11 current level nested", int'(cur_level), 6);
        tmr_req = 1'b0;
        do_ret();
        chk(in_service == 16'h0080, "R4 only top retired", int'(in_service), 16'h0080);
        expect_take(9, "R3 waiting level entered after return");
        do_ret();
        tick(2);
        chk(in_service == 16'h0200, "R3 level 9 in service", int'(in_service), 16'h0200);
        do_ret();
        gp_req[2] = 1'b0;

        // R2 simultaneous pending, R8 software raise, R6 mask bit 4
        wr_mask(16'hFFFF);
        expect_take(5, "R2 first of three");
        expect_take(10, "R2 second of three");
        expect_take(15, "R8 top software level");
        hwerr_req = 1'b1;
        sw_raise  = 9'b1_0000_1000;
        tick(1);
        sw_raise  = '0;
        tick(3);
        chk(in_service == 16'h0020, "R2 most urgent first", int'(in_service), 16'h0020);
        do_ret();
        tick(1);
        chk(in_service == 16'h0400, "R2 second entry", int'(in_service), 16'h0400);
        do_ret();
        tick(1);
        chk(in_service == 16'h8000, "R8 level 15 by software", int'(in_service), 16'h8000);
        do_ret();
        hwerr_req = 1'b0;
        tick(3);
        chk(in_service == '0 && !take_pulse, "R6 nothing from reserved level", int'(in_service), 0);

        // R12 exception ignores mask and preempts general-purpose service
        wr_mask(16'h0800);
        expect_take(11, "R8 level 11 by software");
        sw_pulse(4);
        tick(3);
        expect_take(3, "R12 exception entry");
        exc_req = 1'b1;
        tick(3);
        chk(in_service == 16'h0808 && cur_level == 4'd3, "R12 exception over general level", int'(in_service), 16'h0808);
        expect_take(0, "R12 emulation over exception");
        emu_req = 1'b1;
        tick(3);
        chk(in_service == 16'h0809, "R12 emulation nested", int'(in_service), 16'h0809);
        emu_req = 1'b0;
        exc_req = 1'b0;
        do_ret();
        do_ret();
        do_ret();
        chk(in_service == '0, "R4 three returns unwind", int'(in_service), 0);

        // R7 three NMI sources
        expect_take(2, "R7 nmi from pin");
        nmi_pin = 1'b1;
        tick(3);
        chk(cur_level == 4'd2, "R7 pin raises level 2", int'(cur_level), 2);
        do_ret();
        nmi_pin = 1'b0;
        expect_take(2, "R7 nmi from watchdog");
        nmi_wdog = 1'b1;
        tick(1);
        nmi_wdog = 1'b0;
        tick(2);
        chk(cur_level == 4'd2 && cur_vld, "R7 watchdog raises level 2", int'(cur_level), 2);
        do_ret();
        expect_take(2, "R7 nmi from software");
        nmi_sw = 1'b1;
        tick(1);
        nmi_sw = 1'b0;
        tick(2);
        chk(cur_level == 4'd2 && cur_vld, "R7 software raises level 2", int'(cur_level), 2);
        do_ret();

        // R9 edge capture
        wr_mask(16'h0100);
        expect_take(8, "R9 first edge");
        gp_req[1] = 1'b1;
        tick(3);
        do_ret();
        tick(5);
        chk(in_service == '0, "R9 held line not retaken", int'(in_service), 0);
        gp_req[1] = 1'b0;
        tick(1);
        expect_take(8, "R9 second edge");
        gp_req[1] = 1'b1;
        tick(3);
        chk(in_service == 16'h0100, "R9 new edge taken", int'(in_service), 16'h0100);
        do_ret();
        gp_req[1] = 1'b0;

        // R10 entry timing
        wr_mask(16'h1000);
        tick(1);
        expect_take(12, "R10 entry vector");
        sw_raise[5] = 1'b1;
        tick(1);
        sw_raise = '0;
        chk(take_pulse == 1'b0, "R10 pending only after first edge", int'(take_pulse), 0);
        tick(1);
        chk(take_pulse == 1'b1 && take_vec == 4'd12, "R10 pulse after second edge", int'(take_vec), 12);
        tick(1);
        chk(take_pulse == 1'b0, "R10 pulse lasts one cycle", int'(take_pulse), 0);
        do_ret();

        // R4 return on the clock an entry would happen
        wr_mask(16'h00A0);
        expect_take(7, "R4 setup entry");
        sw_pulse(0);
        tick(3);
        hwerr_req = 1'b1;
        tick(1);
        ret_strobe = 1'b1;
        tick(1);
        ret_strobe = 1'b0;
        chk(in_service == '0 && !take_pulse, "R4 no entry on return clock", int'(in_service), 0);
        expect_take(5, "R4 entry after return clock");
        tick(1);
        chk(take_pulse && take_vec == 4'd5, "R4 deferred entry", int'(take_vec), 5);
        do_ret();
        hwerr_req = 1'b0;
        do_ret();
        chk(in_service == '0 && !cur_vld, "R4 return with nothing in service", int'(in_service), 0);

        tick(5);
        chk(exp_q.size() == 0, "R3 all expected entries seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule